// File: doc/BRIEF.md
# Serial-In Shifter with Latched Parallel Outputs

This block turns a serial bit stream into an 8-bit parallel word. Bits enter a chain of shift stages on the rising edge of a shift clock. A second, independent storage clock copies the whole chain into a storage register in one step. The storage register drives eight parallel lines, so the word seen downstream changes only when the storage clock fires. Between storage edges, software or a controller can shift a new word in without disturbing the lines.

The last shift stage also appears on a serial cascade output, taken ahead of the storage register. Several units can be chained by wiring each cascade output to the serial input of the next unit. They then share both clocks, and one storage edge updates every unit together.

An asynchronous active-low clear empties the shift chain only; the storage register keeps its contents. An active-low output enable controls the parallel lines: while it is high they are high-impedance, so another driver can take over the bus. The cascade output is driven at all times.

Top module: `sipo_latch_shifter`

## Requirements
- R1: On each rising edge of `sh_clk` with `clr_n` high, `ser_in` enters stage 0 and stage i moves to stage i+1; the old stage 7 bit is lost. Stage i maps to `par_q[i]`, so the first of eight shifted bits ends at `par_q[7]` after the next storage edge.
- R2: On a rising edge of `st_clk`, all eight stage values are copied into the storage register at once. Between storage edges, `par_q` keeps its value whatever happens on `sh_clk`.
- R3: When `sh_clk` and `st_clk` rise together, the storage register takes the stage values from before that edge, so the shift chain stays one pulse ahead.
- R4: `ser_out` always equals stage 7, and is not affected by `oe_n`.
- R5: `clr_n` low forces all stages to zero at once, without any clock. This makes `ser_out` 0, and `sh_clk` edges have no effect while `clr_n` stays low.
- R6: With `oe_n` high, `par_q` is high-impedance, so an outside driver on the same lines sets their value. With `oe_n` low, `par_q` drives the stored word.
- R7: `clr_n` does not change the storage register: `par_q` keeps the last stored word during and after a clear, until the next `st_clk` edge.
- R8: A rising edge of `st_clk` while `clr_n` is low loads all zeros.
- R9: Two units are chained by connecting `ser_out` of the first to `ser_in` of the second, with both clocks shared. After 16 shift pulses and one storage pulse, the second unit holds the first eight bits shifted and the first unit holds the last eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data bit sampled on the shift clock |
| sh_clk | input | 1 | Shift clock, rising edge active |
| st_clk | input | 1 | Storage clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_q | output | 8 | Parallel lines from the storage register, high-impedance when disabled |
| ser_out | output | 1 | Cascade output, copy of the last shift stage |

## Verification
A shifted bit is in its stage right after the `sh_clk` rising edge, and `ser_out` shows it at once. `par_q` changes only right after a `st_clk` rising edge. Clear and output enable act combinationally on `ser_out` and `par_q`. The bench therefore samples one time unit after each clock falls or each control input changes, and checks `par_q` both before and after a storage pulse, so that a word which moves early is caught. It sweeps all 256 words through one unit, and through the chained pair at the same time.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Number of shift stages and storage bits in one unit
    parameter int unsigned LANES = 8;

    // Saturating count of shift edges since the last clear, used by checks
    localparam int unsigned WARM_MAX = 2;
    localparam int unsigned WARM_W   = $clog2(WARM_MAX + 1);

    typedef logic [LANES-1:0]  lane_t;
    typedef logic [WARM_W-1:0] warm_t;

    // Control inputs grouped for the top level
    typedef struct packed {
        logic clear_n;
        logic drive_n;
    } ctl_t;

    // Word expected after one shift: new bit at stage 0
    function automatic lane_t advance(input lane_t cur, input logic bit_in);
        return {cur[LANES-2:0], bit_in};
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
    import sipo_pkg::*;
#(
    parameter int unsigned N = LANES
) (
    input  logic         sh_clk,
    input  logic         clr_n,
    input  logic         ser_in,
    output logic [N-1:0] stages,
    output logic         ser_out
);

    localparam int unsigned LAST = N - 1;

    // One flop per stage; stage 0 takes the serial input
    for (genvar i = 0; i < N; i++) begin : g_stage
        logic nxt;
        if (i == 0) begin : g_head
            assign nxt = ser_in;
        end else begin : g_body
            assign nxt = stages[i-1];
        end
        always_ff @(posedge sh_clk or negedge clr_n) begin
            if (!clr_n) stages[i] <= 1'b0;
            else        stages[i] <= nxt;
        end
    end

    assign ser_out = stages[LAST];

    // Edges seen since the last clear, saturating
    warm_t warm;
    always_ff @(posedge sh_clk or negedge clr_n) begin
        if (!clr_n)                    warm <= '0;
        else if (warm != warm_t'(WARM_MAX)) warm <= warm + warm_t'(1);
    end

    // R1
    shift_adv_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
        (warm >= warm_t'(1)) |-> (stages[0] == $past(ser_in)));

    // R4
    cascade_tap_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
        (warm >= warm_t'(2)) |-> (ser_out == $past(stages[LAST-1])));

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg
    import sipo_pkg::*;
#(
    parameter int unsigned N = LANES
) (
    input  logic         st_clk,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    // No clear here: the stored word survives a clear of the chain
    always_ff @(posedge st_clk) begin
        q <= d;
    end

    // R2
    store_load_chk: assert property (@(posedge st_clk) disable iff (1'b0)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/sipo_bus_drive.sv
module sipo_bus_drive
    import sipo_pkg::*;
#(
    parameter int unsigned N = LANES
) (
    input  logic         oe_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] bus
);

    // One tri-state driver per line
    for (genvar i = 0; i < N; i++) begin : g_line
        assign bus[i] = oe_n ? 1'bz : d[i];
    end

    // R6
    always_comb begin
        if (!oe_n) begin
            bus_drive_chk: assert (bus == d);
        end
    end

endmodule

// File: rtl/sipo_latch_shifter.sv
module sipo_latch_shifter
    import sipo_pkg::*;
#(
    parameter int unsigned N = LANES
) (
    input  logic         ser_in,
    input  logic         sh_clk,
    input  logic         st_clk,
    input  logic         clr_n,
    input  logic         oe_n,
    output logic [N-1:0] par_q,
    output logic         ser_out
);

    ctl_t         ctl;
    logic [N-1:0] chain_w;
    logic [N-1:0] held_w;

    assign ctl.clear_n = clr_n;
    assign ctl.drive_n = oe_n;

    sipo_shift_chain #(.N(N)) u_chain (
        .sh_clk  (sh_clk),
        .clr_n   (ctl.clear_n),
        .ser_in  (ser_in),
        .stages  (chain_w),
        .ser_out (ser_out)
    );

    sipo_hold_reg #(.N(N)) u_hold (
        .st_clk (st_clk),
        .d      (chain_w),
        .q      (held_w)
    );

    sipo_bus_drive #(.N(N)) u_drive (
        .oe_n (ctl.drive_n),
        .d    (held_w),
        .bus  (par_q)
    );

endmodule

// File: tb/sipo_latch_shifter_test.sv
`timescale 1ns/1ps
module sipo_latch_shifter_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic ser_in = 1'b0, sh_clk = 1'b0, st_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b0;
    wire  [7:0] bus_a;
    wire  [7:0] bus_b;
    wire  ser_a, ser_b;
    logic tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;

    assign bus_a = tb_drv ? tb_val : 8'hzz;

    sipo_latch_shifter uut (
        .ser_in(ser_in), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
        .oe_n(oe_n), .par_q(bus_a), .ser_out(ser_a));

    sipo_latch_shifter uut_b (
        .ser_in(ser_a), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
        .oe_n(oe_n), .par_q(bus_b), .ser_out(ser_b));

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sh_pulse(input logic b);
        ser_in = b;
        #2 sh_clk = 1'b1;
        #2 sh_clk = 1'b0;
        #1;
    endtask

    task automatic st_pulse();
        #1 st_clk = 1'b1;
        #2 st_clk = 1'b0;
        #1;
    endtask

    task automatic both_pulse(input logic b);
        ser_in = b;
        #2 begin sh_clk = 1'b1; st_clk = 1'b1; end
        #2 begin sh_clk = 1'b0; st_clk = 1'b0; end
        #1;
    endtask

    task automatic load8(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) sh_pulse(w[i]);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cycles == 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    initial begin
        logic [7:0] prev;
        #10;
        // Reset state: clear held, storage edge loads zeros
        st_pulse();
        chk("R5 ser_out in clear", {31'd0, ser_a}, 32'd0);
        chk("R8 store during clear", {24'd0, bus_a}, 32'd0);
        clr_n = 1'b1;
        #1;

        // Full sweep of words; chained unit holds the previous word
        prev = 8'h00;
        for (int p = 0; p < 256; p++) begin
            load8(8'(p));
            chk("R4 ser_out is stage 7", {31'd0, ser_a}, {31'd0, 1'(p >> 7)});
            chk("R2 par_q before store", {24'd0, bus_a}, {24'd0, prev});
            st_pulse();
            chk("R1 R2 stored word", {24'd0, bus_a}, 32'(p));
            chk("R9 chained word", {24'd0, bus_b}, {24'd0, prev});
            prev = 8'(p);
        end

        // R9: sixteen-bit pattern across the pair
        for (int i = 15; i >= 0; i--) sh_pulse(16'hC3A5 >> i);
        st_pulse();
        chk("R9 16-bit pair", {16'd0, bus_b, bus_a}, 32'h0000C3A5);

        // R3: common clock, storage one pulse behind
        load8(8'h96);
        st_pulse();
        both_pulse(1'b1);
        chk("R3 common edge takes old chain", {24'd0, bus_a}, 32'h96);
        st_pulse();
        chk("R3 next store", {24'd0, bus_a}, 32'h2D);

        // R5, R7, R8: clear behaviour
        load8(8'hB7);
        st_pulse();
        clr_n = 1'b0;
        #1;
        chk("R5 ser_out cleared at once", {31'd0, ser_a}, 32'd0);
        chk("R7 storage kept in clear", {24'd0, bus_a}, 32'hB7);
        sh_pulse(1'b1); sh_pulse(1'b1); sh_pulse(1'b1);
        chk("R5 shift ignored in clear", {31'd0, ser_a}, 32'd0);
        chk("R7 storage kept after shifts", {24'd0, bus_a}, 32'hB7);
        st_pulse();
        chk("R8 zeros loaded", {24'd0, bus_a}, 32'h00);
        clr_n = 1'b1;
        #1;
        sh_pulse(1'b1);
        st_pulse();
        chk("R1 shift after clear", {24'd0, bus_a}, 32'h01);

        // R7: clear after a store leaves par_q until next store
        load8(8'h3C);
        st_pulse();
        clr_n = 1'b0; #2; clr_n = 1'b1; #1;
        chk("R7 stored word survives clear", {24'd0, bus_a}, 32'h3C);

        // R6: output enable
        load8(8'hDA);
        st_pulse();
        oe_n = 1'b1;
        tb_val = 8'h25;
        tb_drv = 1'b1;
        #1;
        chk("R6 lines released", {24'd0, bus_a}, 32'h25);
        chk("R6 ser_out still driven", {31'd0, ser_a}, 32'd1);
        tb_drv = 1'b0;
        oe_n = 1'b0;
        #1;
        chk("R6 lines driven again", {24'd0, bus_a}, 32'hDA);

        done = 1'b1;
        summary();
    end

endmodule